// File: doc/BRIEF.md
# SPI Command-Frame Register Front End for a UART

This block is the host-side register interface of a small UART. A host talks to it as an SPI slave (clock idle low, data captured on the rising clock edge, changed on the falling edge, MSB first) in fixed 16-bit frames. The two leading bits of each frame select one of four operations: load the configuration, hand a character to the transmitter, read back the configuration, or read a receive word. Every frame, whatever its operation, shifts a status word back to the host at the same time.

The block holds the configuration fields and presents them as outputs to the baud divider, transmitter and receiver. It holds the active-low request-to-send output and samples the active-low clear-to-send input. It also builds an active-low interrupt request from masked receiver and transmitter conditions, and from line activity on the receive pin while the UART is shut down. The bit engines, baud divider and receive FIFO are separate blocks. Only their status, strobes and data pass through these ports. The SPI clock, select and data pins are synchronized to the system clock. The SPI clock may run at no more than a quarter of the system clock rate.

Top module: `spiUartRegs`

## Requirements
- R1: After reset, rtsN and irqN are 1, every configuration output is 0, and dout is high-impedance.
- R2: A complete frame with bits[15:14]=11 loads the configuration from its low bits: [3:0] baudDiv, [4] wordLen8, [5] parityEn, [6] fifoEn, [7] irdaMode, [8] shutdown, [12:9] intMask.
- R3: A complete frame with bits[15:14]=10 produces a txWrite pulse exactly one cycle long. With it come txData = bits[7:0] and txParity = bit[8]. When wordLen8 is 0, txData[7] is forced to 0.
- R4: rtsN takes the inverse of bit[9] of the last complete write-data frame and changes at no other time.
- R5: Every frame returns on dout, MSB first, the status word sampled when csN falls: [15] rxReady, [14] txEmpty, [13:11] zero, [10] event bit, [9] inverted ctsN, [8] rxParity, [7:0] rxData.
- R6: A frame with bits[15:14]=01 returns status bits [15:14] followed by the configuration in bits [13:0], in the R2 layout, with bit 13 zero.
- R7: A complete frame with bits[15:14]=00 pulses rxPop for one cycle when rxReady is 1. No other operation pops.
- R8: A frame in which csN rises after fewer than 16 SCLK rising edges changes no configuration, does not move rtsN, and produces no txWrite or rxPop.
- R9: dout is high-impedance whenever csN is 1.
- R10: irqN is low exactly when an enabled source is active. The sources are intMask[0] with rxReady, intMask[1] with txEmpty, intMask[2] with rxParity and rxReady together, and intMask[3] with rxFrameErr.
- R11: While shutdown is 1, any transition on rxLine sets an activity flag that drives irqN low regardless of intMask and reads as status bit 10. Outside shutdown, bit 10 is rxFrameErr. A complete read-data frame clears the flag, and so does leaving shutdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous reset, active high |
| sclk | input | 1 | SPI clock from host |
| csN | input | 1 | SPI select, active low |
| din | input | 1 | SPI data from host |
| dout | output | 1 | SPI data to host, high-impedance when deselected |
| ctsN | input | 1 | Clear-to-send, active low |
| rtsN | output | 1 | Request-to-send, active low |
| irqN | output | 1 | Interrupt request, active low |
| rxLine | input | 1 | Receive serial line, watched for activity in shutdown |
| rxData | input | 8 | Oldest receive FIFO entry |
| rxParity | input | 1 | Parity bit of the oldest entry |
| rxReady | input | 1 | Receive FIFO holds data |
| rxFrameErr | input | 1 | Framing error of the oldest entry |
| rxPop | output | 1 | Pop strobe to the receive FIFO |
| txEmpty | input | 1 | Transmit buffer can accept a character |
| txWrite | output | 1 | Load strobe to the transmitter |
| txData | output | 8 | Character for the transmitter |
| txParity | output | 1 | Parity bit to send |
| baudDiv | output | 4 | Baud divisor select |
| wordLen8 | output | 1 | 1 = 8-bit characters, 0 = 7-bit |
| parityEn | output | 1 | Parity bit enable |
| fifoEn | output | 1 | Receive FIFO enable |
| irdaMode | output | 1 | Infrared pulse timing select |
| shutdown | output | 1 | Low-power shutdown |
| intMask | output | 4 | Interrupt source enables |

## Verification
A wrong bit count or opcode latch shows up at the end of the frame concerned. It appears as a configuration output that changes, or fails to change, or as a txWrite or rxPop pulse that is missing or extra, a few system clocks after the sixteenth SCLK edge. A corrupted return shifter shows on dout in the same frame. It is seen either from the first bit or, in a configuration read, from bit 13 on, when the readback is spliced in. A stuck activity flag or a wrong mask keeps irqN in the wrong state within a few clocks of a source change, and the next read-data frame exposes the flag through status bit 10.

// File: rtl/spiUartPkg.sv
package spiUartPkg;
  localparam int FRAME_W = 16;
  localparam int OP_W    = 2;
  localparam int CHAR_W  = 8;
  localparam int DIV_W   = 4;
  localparam int MASK_W  = 4;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  typedef enum logic [OP_W-1:0] {
    OP_RD_DATA = 2'b00,
    OP_RD_CFG  = 2'b01,
    OP_WR_DATA = 2'b10,
    OP_WR_CFG  = 2'b11
  } opcode_e;

  // packed order puts baudDiv at the LSBs, matching the frame layout
  typedef struct packed {
    logic [MASK_W-1:0] intMask;
    logic              shutdown;
    logic              irdaMode;
    logic              fifoEn;
    logic              parityEn;
    logic              wordLen8;
    logic [DIV_W-1:0]  baudDiv;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

  typedef struct packed {
    logic loadResp;
    logic shiftIn;
    logic shiftOut;
    logic patchCfg;
    logic commit;
    logic dinBit;
  } strobe_t;
endpackage

// File: rtl/spiRegCtrl.sv
module spiRegCtrl
  import spiUartPkg::*;
#(
  parameter int SyncStages = 2
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    sclk,
  input  logic    csN,
  input  logic    din,
  output strobe_t strb
);
  logic [SyncStages-1:0] sclkSync, csSync, dinSync;
  logic sclkPrev, csPrev;
  logic [CNT_W-1:0] bitCnt;
  logic sclkNow, csNow, riseEv, fallEv, csFallEv, inFrame;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      sclkSync <= '0;
      csSync   <= '1;
      dinSync  <= '0;
      sclkPrev <= 1'b0;
      csPrev   <= 1'b1;
    end else begin
      sclkSync <= {sclkSync[SyncStages-2:0], sclk};
      csSync   <= {csSync[SyncStages-2:0], csN};
      dinSync  <= {dinSync[SyncStages-2:0], din};
      sclkPrev <= sclkNow;
      csPrev   <= csNow;
    end
  end

  assign sclkNow  = sclkSync[SyncStages-1];
  assign csNow    = csSync[SyncStages-1];
  assign riseEv   = sclkNow & ~sclkPrev & ~csNow;
  assign fallEv   = ~sclkNow & sclkPrev & ~csNow;
  assign csFallEv = ~csNow & csPrev;
  assign inFrame  = bitCnt < CNT_W'(FRAME_W);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) bitCnt <= '0;
    else if (csNow || csFallEv) bitCnt <= '0;
    else if (riseEv && inFrame) bitCnt <= bitCnt + 1'b1;
  end

  always_comb begin
    strb.loadResp = csFallEv;
    strb.shiftIn  = riseEv && inFrame;
    strb.shiftOut = fallEv && inFrame;
    strb.patchCfg = riseEv && (bitCnt == CNT_W'(OP_W - 1));
    strb.commit   = riseEv && (bitCnt == CNT_W'(FRAME_W - 1));
    strb.dinBit   = dinSync[SyncStages-1];
  end
endmodule

// File: rtl/spiRegData.sv
module spiRegData
  import spiUartPkg::*;
#(
  parameter int SyncStages = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strb,
  input  logic              csN,
  input  logic              ctsN,
  input  logic              rxLine,
  input  logic [CHAR_W-1:0] rxData,
  input  logic              rxParity,
  input  logic              rxReady,
  input  logic              rxFrameErr,
  input  logic              txEmpty,
  output logic              dout,
  output logic              irqN,
  output logic              rtsN,
  output cfg_t              cfgReg,
  output logic              txWrite,
  output logic [CHAR_W-1:0] txData,
  output logic              txParity,
  output logic              rxPop
);
  localparam int PAD_W = FRAME_W - CHAR_W - 5;

  logic [FRAME_W-2:0] rxShift;
  logic [FRAME_W-1:0] dataOut, respWord;
  logic [SyncStages-1:0] ctsSync, rxSync;
  logic rxPrev, actFlag, eventBit;
  logic [MASK_W-1:0] srcVec;
  opcode_e opNow;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      ctsSync <= '1;
      rxSync  <= '1;
      rxPrev  <= 1'b1;
    end else begin
      ctsSync <= {ctsSync[SyncStages-2:0], ctsN};
      rxSync  <= {rxSync[SyncStages-2:0], rxLine};
      rxPrev  <= rxSync[SyncStages-1];
    end
  end

  assign eventBit = cfgReg.shutdown ? actFlag : rxFrameErr;
  assign respWord = {rxReady, txEmpty, PAD_W'(0), eventBit,
                     ~ctsSync[SyncStages-1], rxParity, rxData};
  assign opNow    = opcode_e'(rxShift[FRAME_W-2:FRAME_W-3]);

  // return shifter: load at select, shift on falling SCLK, splice config after opcode
  always_ff @(posedge clk or posedge rst) begin
    if (rst) dataOut <= '0;
    else if (strb.loadResp) dataOut <= respWord;
    else if (strb.shiftOut) dataOut <= {dataOut[FRAME_W-2:0], 1'b0};
    else if (strb.patchCfg && ({rxShift[0], strb.dinBit} == OP_RD_CFG))
      dataOut[FRAME_W-2:1] <= (FRAME_W-OP_W)'(cfgReg);
  end

  assign dout = csN ? 1'bz : dataOut[FRAME_W-1];

  always_ff @(posedge clk or posedge rst) begin
    if (rst) rxShift <= '0;
    else if (strb.shiftIn) rxShift <= {rxShift[FRAME_W-3:0], strb.dinBit};
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      cfgReg   <= '0;
      rtsN     <= 1'b1;
      txWrite  <= 1'b0;
      txData   <= '0;
      txParity <= 1'b0;
      rxPop    <= 1'b0;
    end else begin
      txWrite <= 1'b0;
      rxPop   <= 1'b0;
      if (strb.commit) begin
        case (opNow)
          OP_WR_CFG:  cfgReg <= cfg_t'({rxShift[CFG_W-2:0], strb.dinBit});
          OP_WR_DATA: begin
            txWrite  <= 1'b1;
            txData   <= {cfgReg.wordLen8 & rxShift[CHAR_W-2],
                         rxShift[CHAR_W-3:0], strb.dinBit};
            txParity <= rxShift[CHAR_W-1];
            rtsN     <= ~rxShift[CHAR_W];
          end
          OP_RD_DATA: rxPop <= rxReady;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) actFlag <= 1'b0;
    else if (!cfgReg.shutdown) actFlag <= 1'b0;
    else if (rxSync[SyncStages-1] != rxPrev) actFlag <= 1'b1;
    else if (strb.commit && opNow == OP_RD_DATA) actFlag <= 1'b0;
  end

  assign srcVec = {rxFrameErr, rxParity & rxReady, txEmpty, rxReady};

  always_ff @(posedge clk or posedge rst) begin
    if (rst) irqN <= 1'b1;
    else irqN <= ~(|(cfgReg.intMask & srcVec) | actFlag);
  end
endmodule

// File: rtl/spiUartRegs.sv
module spiUartRegs
  import spiUartPkg::*;
#(
  parameter int SyncStages = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              csN,
  input  logic              din,
  output logic              dout,
  input  logic              ctsN,
  output logic              rtsN,
  output logic              irqN,
  input  logic              rxLine,
  input  logic [CHAR_W-1:0] rxData,
  input  logic              rxParity,
  input  logic              rxReady,
  input  logic              rxFrameErr,
  output logic              rxPop,
  input  logic              txEmpty,
  output logic              txWrite,
  output logic [CHAR_W-1:0] txData,
  output logic              txParity,
  output logic [DIV_W-1:0]  baudDiv,
  output logic              wordLen8,
  output logic              parityEn,
  output logic              fifoEn,
  output logic              irdaMode,
  output logic              shutdown,
  output logic [MASK_W-1:0] intMask
);
  strobe_t strb;
  cfg_t    cfgReg;

  spiRegCtrl #(.SyncStages(SyncStages)) i_ctrl (
    .clk(clk), .rst(rst), .sclk(sclk), .csN(csN), .din(din), .strb(strb)
  );

  spiRegData #(.SyncStages(SyncStages)) i_data (
    .clk(clk), .rst(rst), .strb(strb), .csN(csN), .ctsN(ctsN),
    .rxLine(rxLine), .rxData(rxData), .rxParity(rxParity),
    .rxReady(rxReady), .rxFrameErr(rxFrameErr), .txEmpty(txEmpty),
    .dout(dout), .irqN(irqN), .rtsN(rtsN), .cfgReg(cfgReg),
    .txWrite(txWrite), .txData(txData), .txParity(txParity), .rxPop(rxPop)
  );

  assign baudDiv  = cfgReg.baudDiv;
  assign wordLen8 = cfgReg.wordLen8;
  assign parityEn = cfgReg.parityEn;
  assign fifoEn   = cfgReg.fifoEn;
  assign irdaMode = cfgReg.irdaMode;
  assign shutdown = cfgReg.shutdown;
  assign intMask  = cfgReg.intMask;
endmodule

// File: rtl/spiUartRegsChk.sv
module spiUartRegsChk
  import spiUartPkg::*;
(
  input logic              clk,
  input logic              rst,
  input strobe_t           strb,
  input logic [CFG_W-1:0]  cfgBits,
  input logic              rtsN,
  input logic              txWrite,
  input logic              rxPop,
  input logic              rxReady,
  input logic              irqN,
  input logic [MASK_W-1:0] intMask,
  input logic              shutdown
);
  // R3
  tx_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    txWrite |=> !txWrite);

  // R4
  rts_moves_with_write_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(rtsN) |-> txWrite);

  // R2
  cfg_only_on_commit_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfgBits) |-> $past(strb.commit));

  // R7
  pop_needs_data_chk: assert property (@(posedge clk) disable iff (rst)
    rxPop |-> $past(rxReady));

  // R10
  irq_quiet_when_masked_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(intMask == '0 && !shutdown) && $past(intMask == '0 && !shutdown, 2)) |-> irqN);
endmodule

bind spiUartRegs spiUartRegsChk i_chk (
  .clk(clk), .rst(rst), .strb(strb), .cfgBits(cfgReg), .rtsN(rtsN),
  .txWrite(txWrite), .rxPop(rxPop), .rxReady(rxReady), .irqN(irqN),
  .intMask(intMask), .shutdown(shutdown)
);

// File: tb/test_spiUartRegs.sv
`timescale 1ns/1ps
module test_spiUartRegs;
  localparam int HALF = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic sclk = 1'b0, csN = 1'b1, din = 1'b0, ctsN = 1'b1, rxLine = 1'b1;
  logic [7:0] rxData = 8'h00;
  logic rxParity = 1'b0, rxReady = 1'b0, rxFrameErr = 1'b0, txEmpty = 1'b0;
  logic dout, rtsN, irqN, rxPop, txWrite, txParity;
  logic [7:0] txData;
  logic [3:0] baudDiv, intMask;
  logic wordLen8, parityEn, fifoEn, irdaMode, shutdown;

  int errors = 0, checks = 0, txCnt = 0, popCnt = 0;
  logic [7:0] lastTx;
  logic lastPar;
  logic [15:0] resp;
  bit done = 0;

  always #2.5 clk = ~clk;

  spiUartRegs i_spiUartRegs (
    .clk(clk), .rst(rst), .sclk(sclk), .csN(csN), .din(din), .dout(dout),
    .ctsN(ctsN), .rtsN(rtsN), .irqN(irqN), .rxLine(rxLine), .rxData(rxData),
    .rxParity(rxParity), .rxReady(rxReady), .rxFrameErr(rxFrameErr),
    .rxPop(rxPop), .txEmpty(txEmpty), .txWrite(txWrite), .txData(txData),
    .txParity(txParity), .baudDiv(baudDiv), .wordLen8(wordLen8),
    .parityEn(parityEn), .fifoEn(fifoEn), .irdaMode(irdaMode),
    .shutdown(shutdown), .intMask(intMask)
  );

  always @(posedge clk) begin
    if (txWrite) begin txCnt++; lastTx = txData; lastPar = txParity; end
    if (rxPop) popCnt++;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spiXfer(input logic [15:0] word, input int nbits, output logic [15:0] r);
    r = '0;
    csN = 1'b0;
    waitClk(HALF);
    for (int i = 0; i < nbits; i++) begin
      din = word[15-i];
      waitClk(HALF);
      r[15-i] = dout;
      sclk = 1'b1;
      waitClk(HALF);
      sclk = 1'b0;
    end
    waitClk(HALF);
    csN = 1'b1;
    waitClk(10);
  endtask

  task automatic testReset();
    check("R1 rtsN", rtsN, 1);
    check("R1 irqN", irqN, 1);
    check("R1 cfg", {baudDiv, wordLen8, parityEn, fifoEn, irdaMode, shutdown, intMask}, 0);
    check("R9 dout idle", dout, 1'bz);
  endtask

  task automatic testWriteCfg();
    spiXfer(16'hC0BA, 16, resp);
    check("R5 idle status", resp, 16'h0000);
    check("R2 baudDiv", baudDiv, 4'hA);
    check("R2 flags", {wordLen8, parityEn, fifoEn, irdaMode, shutdown}, 5'b11010);
    check("R2 intMask", intMask, 0);
  endtask

  task automatic testReadCfg();
    txEmpty = 1'b1;
    spiXfer(16'h4000, 16, resp);
    check("R6 config readback", resp, 16'h40BA);
  endtask

  task automatic testWriteData();
    int t0 = txCnt, p0 = popCnt;
    spiXfer(16'h83A5, 16, resp);
    check("R3 one pulse", txCnt - t0, 1);
    check("R3 txData", lastTx, 8'hA5);
    check("R3 txParity", lastPar, 1);
    check("R4 rts asserted", rtsN, 0);
    check("R7 no pop on write", popCnt - p0, 0);
  endtask

  task automatic testReadData();
    int p0 = popCnt;
    rxReady = 1; rxData = 8'h5C; rxParity = 1; rxFrameErr = 1; ctsN = 0;
    waitClk(6);
    spiXfer(16'h0000, 16, resp);
    check("R5 full status", resp, 16'hC75C);
    check("R7 pop", popCnt - p0, 1);
    rxReady = 0; rxParity = 0; rxFrameErr = 0; ctsN = 1;
    waitClk(6);
    spiXfer(16'h0000, 16, resp);
    check("R5 cleared status", resp, 16'h405C);
    check("R7 no pop when empty", popCnt - p0, 1);
  endtask

  task automatic testSevenBit();
    spiXfer(16'hC0AA, 16, resp);
    check("R2 7-bit mode", wordLen8, 0);
    spiXfer(16'h80C3, 16, resp);
    check("R3 bit7 forced", lastTx, 8'h43);
    check("R4 rts released", rtsN, 1);
  endtask

  task automatic testShortFrames();
    int t0 = txCnt, p0 = popCnt;
    spiXfer(16'hC3FF, 10, resp);
    check("R8 cfg kept", {baudDiv, wordLen8, intMask}, {4'hA, 1'b0, 4'h0});
    spiXfer(16'h82FF, 15, resp);
    check("R8 no tx", txCnt - t0, 0);
    check("R8 rts kept", rtsN, 1);
    rxReady = 1;
    spiXfer(16'h0000, 15, resp);
    check("R8 no pop", popCnt - p0, 0);
  endtask

  task automatic testIrq();
    waitClk(6);
    check("R10 masked off", irqN, 1);
    spiXfer(16'hC2AA, 16, resp);
    check("R10 rxReady source", irqN, 0);
    rxReady = 0; waitClk(6);
    check("R10 source gone", irqN, 1);
    spiXfer(16'hC4AA, 16, resp);
    txEmpty = 1; waitClk(6);
    check("R10 txEmpty source", irqN, 0);
    txEmpty = 0; waitClk(6);
    check("R10 txEmpty gone", irqN, 1);
  endtask

  task automatic testShutdown();
    spiXfer(16'hC1AA, 16, resp);
    check("R2 shutdown", shutdown, 1);
    check("R11 quiet before edge", irqN, 1);
    rxLine = 0; waitClk(10);
    check("R11 activity irq", irqN, 0);
    spiXfer(16'h0000, 16, resp);
    check("R11 activity bit", resp, 16'h045C);
    check("R11 cleared by read", irqN, 1);
    spiXfer(16'hC0AA, 16, resp);
    rxLine = 1; waitClk(10);
    check("R11 no irq outside shutdown", irqN, 1);
    spiXfer(16'h0000, 16, resp);
    check("R11 bit10 is frame error", resp, 16'h005C);
  endtask

  initial begin
    waitClk(10);
    rst = 0;
    waitClk(4);
    testReset();
    testWriteCfg();
    testReadCfg();
    testWriteData();
    testReadData();
    testSevenBit();
    testShortFrames();
    testIrq();
    testShutdown();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule